// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level, in-memory page table. A request supplies a 32-bit virtual address, the access kind (read or write), the privilege of the requester (user or supervisor) and the physical base of the directory. The walker reads one directory entry. If that entry allows the access, it reads one table entry. It then returns either a translation ready to be filled into a translation cache, or a page fault that explains why the walk stopped.

While walking, the walker sets the accessed flag in both entries and sets the dirty flag in the leaf entry on writes. It writes an entry back to memory only when one of these flags actually changes. All memory traffic uses one 32-bit port. Each request on that port is a valid/ready handshake. A request held under back-pressure keeps its address, direction and data unchanged until it is accepted. A write completes at its handshake and returns nothing. A read returns its word later as a single-cycle `mem_rsp_valid` pulse, and the walker always accepts that pulse. New walks enter through `req_valid`/`req_ready`, and `req_ready` is high only while the walker is idle. The result is a one-cycle `rsp_valid` pulse with no back-pressure.

Top module: `ptw_walker`

## Requirements
- R1: The directory entry is read at `req_dir_base + 4*va[31:22]`. The table entry is read at `{dir_entry[31:12], va[21:12], 2'b00}`.
- R2: `req_ready` is high only while idle. After a request is accepted, exactly one `rsp_valid` pulse follows, lasting one cycle.
- R3: If the directory entry has bit 0 (present) clear, the walk ends with `rsp_cause`=1 (not present) and makes no further memory access.
- R4: If a present directory entry has bit 7 (large page) set, the walk ends with `rsp_cause`=3 and makes no further memory access.
- R5: Protection violations end the walk with `rsp_cause`=2. This happens for a user access when bit 2 (user allowed) is clear at either level, and for a write when bit 1 (writable) is clear at either level. Supervisor accesses ignore bit 2, and reads ignore bit 1.
- R6: If the table entry has bit 0 clear, the walk ends with `rsp_cause`=1 after exactly two reads.
- R7: A fault reports the request's address, write flag and user flag on `rsp_va`, `rsp_write` and `rsp_user`. Checks run in the order present, then large page, then protection.
- R8: A directory entry that passes its checks and has bit 5 (accessed) clear is written back with bit 5 set before the table read. The write-back happens even if the table step later faults. The write is skipped when bit 5 is already set.
- R9: On a successful walk, the table entry is written back with bit 5 set, and also bit 6 (dirty) set for writes, but only if this changes the entry. A walk that faults at the table makes no table write.
- R10: On success, `rsp_cause`=0, `fill_vpn`=va[31:12] and `fill_pfn`=table entry[31:12]. The attribute bits of `fill_attr` are: [0] writable at both levels, [1] user at both levels, [2] write-through (table bit 3), [3] cache disable (table bit 4), [4] global (table bit 8), [5] dirty after update.
- R11: A memory request held under back-pressure keeps `mem_addr`, `mem_we` and `mem_wdata` stable until it is accepted. Every write sets bits 0 and 5 of the word written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user mode |
| req_dir_base | input | 32 | Physical base of the directory |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = write request |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Result valid (one cycle) |
| rsp_cause | output | 2 | 0 ok, 1 not present, 2 protection, 3 large page |
| rsp_va | output | 32 | Address of the walk |
| rsp_write | output | 1 | Access was a write |
| rsp_user | output | 1 | Access was from user mode |
| fill_vpn | output | 20 | Virtual page number for the fill |
| fill_pfn | output | 20 | Physical frame number for the fill |
| fill_attr | output | 6 | Fill attributes as in R10 |

## Verification
The checker watches every cycle for four things. It checks that the result pulse lasts a single cycle. It checks that the walker never accepts a request while its memory port is busy. It checks that a stalled memory request holds steady. It checks that every write-back carries the present and accessed bits. The scenarios cover what depends on table contents: which fault cause wins and in which order, how many reads and writes each case makes, the exact addresses read, the values written back, and the filled frame and attributes. Those only show up against a memory model that holds known entries.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  // Entry bit positions (behaviour depends on them)
  localparam int B_PRES = 0;
  localparam int B_RW   = 1;
  localparam int B_US   = 2;
  localparam int B_WT   = 3;
  localparam int B_CD   = 4;
  localparam int B_ACC  = 5;
  localparam int B_DRT  = 6;
  localparam int B_LPG  = 7;
  localparam int B_GLB  = 8;

  localparam int ATTR_W = 6;
  localparam int LEVELS = 2;

  typedef enum logic [1:0] {
    CZ_NONE   = 2'd0,
    CZ_ABSENT = 2'd1,
    CZ_PROT   = 2'd2,
    CZ_LARGE  = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DIR_RD,
    S_DIR_WAIT,
    S_DIR_WB,
    S_TBL_RD,
    S_TBL_WAIT,
    S_TBL_WB,
    S_DONE
  } walk_st_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic [VA_W-1:0]       dir_base,
  input  logic [IDX_W-1:0]      dir_idx,
  input  logic [IDX_W-1:0]      tbl_idx,
  input  logic [VA_W-OFF_W-1:0] tbl_frame,
  output logic [VA_W-1:0]       dir_addr,
  output logic [VA_W-1:0]       tbl_addr
);
  localparam int ENT_LG = 2;                  // 4-byte entries
  localparam int PAD_W  = VA_W - IDX_W - ENT_LG;

  assign dir_addr = dir_base + {{PAD_W{1'b0}}, dir_idx, {ENT_LG{1'b0}}};
  assign tbl_addr = {tbl_frame, tbl_idx, {ENT_LG{1'b0}}};
endmodule

// File: rtl/ptw_entry_chk.sv
module ptw_entry_chk
  import ptw_pkg::*;
#(
  parameter int ENT_W = 32,
  parameter bit LEAF  = 1'b0
) (
  input  logic [ENT_W-1:0] entry,
  input  logic             is_write,
  input  logic             is_user,
  output cause_e           cause,
  output logic [ENT_W-1:0] upd,
  output logic             need_wb
);
  logic prot_bad;
  logic size_bad;

  assign prot_bad = (is_user && !entry[B_US]) || (is_write && !entry[B_RW]);

  generate
    if (LEAF) begin : g_leaf
      assign size_bad = 1'b0;
      always_comb begin
        upd         = entry;
        upd[B_ACC]  = 1'b1;
        if (is_write) upd[B_DRT] = 1'b1;
      end
    end else begin : g_dir
      assign size_bad = entry[B_LPG];
      always_comb begin
        upd        = entry;
        upd[B_ACC] = 1'b1;
      end
    end
  endgenerate

  assign need_wb = (upd != entry);

  always_comb begin
    if (!entry[B_PRES])  cause = CZ_ABSENT;
    else if (size_bad)   cause = CZ_LARGE;
    else if (prot_bad)   cause = CZ_PROT;
    else                 cause = CZ_NONE;
  end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [VA_W-1:0]             req_va,
  input  logic                        req_write,
  input  logic                        req_user,
  input  logic [VA_W-1:0]             req_dir_base,
  output logic                        mem_req_valid,
  input  logic                        mem_req_ready,
  output logic                        mem_we,
  output logic [VA_W-1:0]             mem_addr,
  output logic [VA_W-1:0]             mem_wdata,
  input  logic                        mem_rsp_valid,
  input  cause_e                      chk_cause [LEVELS],
  input  logic [LEVELS-1:0][VA_W-1:0] chk_upd,
  input  logic [LEVELS-1:0]           chk_wb,
  input  logic [VA_W-1:0]             dir_addr,
  input  logic [VA_W-1:0]             tbl_addr,
  output logic [VA_W-1:0]             base_q,
  output logic [VA_W-1:0]             va_q,
  output logic [VA_W-1:0]             dir_q,
  output logic                        wr_q,
  output logic                        usr_q,
  output logic                        rsp_valid,
  output logic [1:0]                  rsp_cause,
  output logic [VA_W-OFF_W-1:0]       fill_pfn,
  output logic [ATTR_W-1:0]           fill_attr
);
  walk_st_e        st;
  cause_e          cause_q;
  logic [VA_W-1:0] tbl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cause_q <= CZ_NONE;
      base_q  <= '0;
      va_q    <= '0;
      dir_q   <= '0;
      tbl_q   <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          base_q  <= req_dir_base;
          va_q    <= req_va;
          wr_q    <= req_write;
          usr_q   <= req_user;
          cause_q <= CZ_NONE;
          st      <= S_DIR_RD;
        end
        S_DIR_RD: if (mem_req_ready) st <= S_DIR_WAIT;
        S_DIR_WAIT: if (mem_rsp_valid) begin
          dir_q <= chk_upd[0];
          if (chk_cause[0] != CZ_NONE) begin
            cause_q <= chk_cause[0];
            st      <= S_DONE;
          end else if (chk_wb[0]) begin
            st <= S_DIR_WB;
          end else begin
            st <= S_TBL_RD;
          end
        end
        S_DIR_WB: if (mem_req_ready) st <= S_TBL_RD;
        S_TBL_RD: if (mem_req_ready) st <= S_TBL_WAIT;
        S_TBL_WAIT: if (mem_rsp_valid) begin
          tbl_q <= chk_upd[1];
          if (chk_cause[1] != CZ_NONE) begin
            cause_q <= chk_cause[1];
            st      <= S_DONE;
          end else if (chk_wb[1]) begin
            st <= S_TBL_WB;
          end else begin
            st <= S_DONE;
          end
        end
        S_TBL_WB: if (mem_req_ready) st <= S_DONE;
        S_DONE:   st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_DIR_RD) || (st == S_DIR_WB) ||
                         (st == S_TBL_RD) || (st == S_TBL_WB);
  assign mem_we        = (st == S_DIR_WB) || (st == S_TBL_WB);

  always_comb begin
    mem_addr  = dir_addr;
    mem_wdata = dir_q;
    if ((st == S_TBL_RD) || (st == S_TBL_WB)) begin
      mem_addr  = tbl_addr;
      mem_wdata = tbl_q;
    end
  end

  assign rsp_valid = (st == S_DONE);
  assign rsp_cause = cause_q;
  assign fill_pfn  = tbl_q[VA_W-1:OFF_W];
  assign fill_attr = {tbl_q[B_DRT], tbl_q[B_GLB], tbl_q[B_CD], tbl_q[B_WT],
                      dir_q[B_US] & tbl_q[B_US], dir_q[B_RW] & tbl_q[B_RW]};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_va,
  input  logic                  req_write,
  input  logic                  req_user,
  input  logic [VA_W-1:0]       req_dir_base,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic                  mem_we,
  output logic [VA_W-1:0]       mem_addr,
  output logic [VA_W-1:0]       mem_wdata,
  input  logic                  mem_rsp_valid,
  input  logic [VA_W-1:0]       mem_rdata,
  output logic                  rsp_valid,
  output logic [1:0]            rsp_cause,
  output logic [VA_W-1:0]       rsp_va,
  output logic                  rsp_write,
  output logic                  rsp_user,
  output logic [VA_W-OFF_W-1:0] fill_vpn,
  output logic [VA_W-OFF_W-1:0] fill_pfn,
  output logic [ATTR_W-1:0]     fill_attr
);
  localparam int FRAME_W = VA_W - OFF_W;
  localparam int DIR_LO  = OFF_W + IDX_W;

  cause_e                      chk_cause [LEVELS];
  logic [LEVELS-1:0][VA_W-1:0] chk_upd;
  logic [LEVELS-1:0]           chk_wb;
  logic [VA_W-1:0]             dir_addr, tbl_addr;
  logic [VA_W-1:0]             base_q, va_q, dir_q;
  logic                        wr_q, usr_q;

  ptw_addr_gen #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_addr (
    .dir_base  (base_q),
    .dir_idx   (va_q[VA_W-1:DIR_LO]),
    .tbl_idx   (va_q[DIR_LO-1:OFF_W]),
    .tbl_frame (dir_q[VA_W-1:OFF_W]),
    .dir_addr  (dir_addr),
    .tbl_addr  (tbl_addr)
  );

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    ptw_entry_chk #(.ENT_W(VA_W), .LEAF(g == LEVELS - 1)) u_chk (
      .entry    (mem_rdata),
      .is_write (wr_q),
      .is_user  (usr_q),
      .cause    (chk_cause[g]),
      .upd      (chk_upd[g]),
      .need_wb  (chk_wb[g])
    );
  end

  ptw_fsm #(.VA_W(VA_W), .OFF_W(OFF_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_va        (req_va),
    .req_write     (req_write),
    .req_user      (req_user),
    .req_dir_base  (req_dir_base),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .chk_cause     (chk_cause),
    .chk_upd       (chk_upd),
    .chk_wb        (chk_wb),
    .dir_addr      (dir_addr),
    .tbl_addr      (tbl_addr),
    .base_q        (base_q),
    .va_q          (va_q),
    .dir_q         (dir_q),
    .wr_q          (wr_q),
    .usr_q         (usr_q),
    .rsp_valid     (rsp_valid),
    .rsp_cause     (rsp_cause),
    .fill_pfn      (fill_pfn),
    .fill_attr     (fill_attr)
  );

  assign rsp_va    = va_q;
  assign rsp_write = wr_q;
  assign rsp_user  = usr_q;
  assign fill_vpn  = va_q[VA_W-1:OFF_W];
endmodule

// File: rtl/ptw_walker_sva.sv
module ptw_walker_sva #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic            mem_we,
  input logic [VA_W-1:0] mem_addr,
  input logic [VA_W-1:0] mem_wdata,
  input logic            rsp_valid
);
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r2_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  a_r2_accept_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r8_wb_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_we) |-> (mem_wdata[0] && mem_wdata[5]));
endmodule

bind ptw_walker ptw_walker_sva #(.VA_W(VA_W)) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .rsp_valid     (rsp_valid)
);

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [31:0] req_dir_base = 32'h0000_1000;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic        mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_cause;
  logic [31:0] rsp_va;
  logic        rsp_write, rsp_user;
  logic [19:0] fill_vpn, fill_pfn;
  logic [5:0]  fill_attr;

  ptw_walker dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .req_user(req_user), .req_dir_base(req_dir_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_cause(rsp_cause), .rsp_va(rsp_va),
    .rsp_write(rsp_write), .rsp_user(rsp_user),
    .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_attr(fill_attr)
  );

  always #4 clk = ~clk;   // 125 MHz

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // memory model state
  logic [31:0] mem [0:4095];
  bit          stall = 1'b0;
  bit          pend = 1'b0;
  logic [31:0] pend_data = '0;
  int          rd_cnt, wr_cnt;
  logic [31:0] rd_addr [2];
  logic [31:0] wr_addr [2];
  logic [31:0] wr_data [2];

  // captured result
  logic [1:0]  c_cause;
  logic [31:0] c_va;
  logic        c_wr, c_usr;
  logic [19:0] c_vpn, c_pfn;
  logic [5:0]  c_attr;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: driven at negedges
  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rdata     = pend_data;
        pend          = 1'b0;
      end
      mem_req_ready = stall ? !mem_req_ready : 1'b1;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (mem_we) begin
          mem[mem_addr[13:2]] = mem_wdata;
          if (wr_cnt < 2) begin
            wr_addr[wr_cnt] = mem_addr;
            wr_data[wr_cnt] = mem_wdata;
          end
          wr_cnt++;
        end else begin
          pend      = 1'b1;
          pend_data = mem[mem_addr[13:2]];
          if (rd_cnt < 2) rd_addr[rd_cnt] = mem_addr;
          rd_cnt++;
        end
      end
    end
  end

  task automatic walk(input logic [31:0] va, input bit wr, input bit usr);
    int guard;
    rd_cnt = 0; wr_cnt = 0;
    for (int i = 0; i < 2; i++) begin rd_addr[i] = 'x; wr_addr[i] = 'x; wr_data[i] = 'x; end
    @(negedge clk);
    guard = 0;
    while (!req_ready && guard < 200) begin @(negedge clk); guard++; end
    req_va = va; req_write = wr; req_user = usr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 500) begin @(negedge clk); guard++; end
    check("R2 response arrived", {31'd0, rsp_valid}, 32'd1);
    c_cause = rsp_cause; c_va = rsp_va; c_wr = rsp_write; c_usr = rsp_user;
    c_vpn = fill_vpn; c_pfn = fill_pfn; c_attr = fill_attr;
    @(negedge clk);
    check("R2 done one cycle", {31'd0, rsp_valid}, 32'd0);
  endtask

  // R2 reset state
  task automatic t_reset();
    check("R2 reset req_ready", {31'd0, req_ready}, 32'd1);
    check("R2 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R11 reset mem idle", {31'd0, mem_req_valid}, 32'd0);
  endtask

  task automatic t_first_read();
    mem[12'h401] = 32'h0000_2007;
    mem[12'h803] = 32'hABCD_E107;
    walk(32'h0040_3ABC, 1'b0, 1'b0);
    check("R10 cause ok", c_cause, 0);
    check("R1 dir addr", rd_addr[0], 32'h0000_1004);
    check("R1 tbl addr", rd_addr[1], 32'h0000_200C);
    check("R8 R9 write count", wr_cnt, 2);
    check("R8 dir wb", wr_data[0], 32'h0000_2027);
    check("R9 tbl wb", wr_data[1], 32'hABCD_E127);
    check("R10 pfn", c_pfn, 32'h000A_BCDE);
    check("R10 vpn", c_vpn, 32'h0000_0403);
    check("R10 attr", c_attr, 32'h13);
  endtask

  task automatic t_repeat_read();
    walk(32'h0040_3ABC, 1'b0, 1'b0);
    check("R8 R9 no wb when set", wr_cnt, 0);
    check("R6 two reads", rd_cnt, 2);
    check("R10 pfn repeat", c_pfn, 32'h000A_BCDE);
  endtask

  task automatic t_write_dirty();
    walk(32'h0040_3ABC, 1'b1, 1'b1);
    check("R10 cause ok write", c_cause, 0);
    check("R9 one wb", wr_cnt, 1);
    check("R9 dirty wb addr", wr_addr[0], 32'h0000_200C);
    check("R9 dirty wb data", wr_data[0], 32'hABCD_E167);
    check("R10 attr dirty", c_attr, 32'h33);
  endtask

  task automatic t_dir_absent();
    mem[12'h405] = 32'h0000_0000;
    walk(32'h0140_5123, 1'b1, 1'b1);
    check("R3 cause", c_cause, 1);
    check("R3 reads", rd_cnt, 1);
    check("R3 writes", wr_cnt, 0);
    check("R7 va", c_va, 32'h0140_5123);
    check("R7 write flag", {31'd0, c_wr}, 1);
    check("R7 user flag", {31'd0, c_usr}, 1);
  endtask

  task automatic t_large();
    mem[12'h406] = 32'h0000_3087;
    walk(32'h0180_0000, 1'b0, 1'b0);
    check("R4 cause", c_cause, 3);
    check("R4 reads", rd_cnt, 1);
    check("R4 writes", wr_cnt, 0);
  endtask

  task automatic t_absent_beats_large();
    mem[12'h40B] = 32'h0000_2080;
    walk(32'h02C0_0000, 1'b0, 1'b0);
    check("R7 order present first", c_cause, 1);
  endtask

  task automatic t_user_denied_dir();
    mem[12'h407] = 32'h0000_3003;
    mem[12'hC00] = 32'h1234_5003;
    walk(32'h01C0_0000, 1'b0, 1'b1);
    check("R5 user dir prot", c_cause, 2);
    check("R5 user dir reads", rd_cnt, 1);
    check("R5 user dir writes", wr_cnt, 0);
    walk(32'h01C0_0000, 1'b0, 1'b0);
    check("R5 supervisor ignores user bit", c_cause, 0);
    check("R8 R9 sup wb count", wr_cnt, 2);
    check("R10 sup attr", c_attr, 32'h01);
    check("R10 sup pfn", c_pfn, 32'h0001_2345);
  endtask

  task automatic t_readonly_tbl();
    mem[12'h408] = 32'h0000_2027;
    mem[12'h804] = 32'h5555_5025;
    walk(32'h0200_4000, 1'b1, 1'b1);
    check("R5 write ro cause", c_cause, 2);
    check("R5 write ro reads", rd_cnt, 2);
    check("R9 no tbl wb on fault", wr_cnt, 0);
    check("R7 write flag ro", {31'd0, c_wr}, 1);
    walk(32'h0200_4000, 1'b0, 1'b1);
    check("R5 read ignores rw", c_cause, 0);
    check("R10 ro attr", c_attr, 32'h02);
    check("R9 ro read no wb", wr_cnt, 0);
  endtask

  task automatic t_tbl_absent();
    mem[12'h409] = 32'h0000_2007;
    mem[12'h805] = 32'h0000_0000;
    walk(32'h0240_5000, 1'b0, 1'b0);
    check("R6 cause", c_cause, 1);
    check("R6 reads", rd_cnt, 2);
    check("R8 dir wb despite tbl fault", wr_cnt, 1);
    check("R8 dir wb value", wr_data[0], 32'h0000_2027);
    check("R8 dir mem", mem[12'h409], 32'h0000_2027);
  endtask

  task automatic t_stalled();
    stall = 1'b1;
    mem[12'h40A] = 32'h0000_3007;
    mem[12'hC01] = 32'hFEDC_B00F;
    walk(32'h0280_1FFF, 1'b1, 1'b0);
    stall = 1'b0;
    check("R11 stall cause", c_cause, 0);
    check("R1 R11 stall dir addr", rd_addr[0], 32'h0000_1028);
    check("R1 R11 stall tbl addr", rd_addr[1], 32'h0000_3004);
    check("R11 stall dir wb", wr_data[0], 32'h0000_3027);
    check("R11 stall tbl wb", wr_data[1], 32'hFEDC_B06F);
    check("R10 stall attr", c_attr, 32'h27);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_read();
    t_repeat_read();
    t_write_dirty();
    t_dir_absent();
    t_large();
    t_absent_beats_large();
    t_user_denied_dir();
    t_readonly_tbl();
    t_tbl_absent();
    t_stalled();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule